// File: doc/BRIEF.md
# Horizontal-Sync-Referenced Gate Pulse Generator

This block produces two timing gates measured from the leading (rising) edge of a horizontal sync. The first is a burst gate used by a colour-burst lock loop. It has a programmable 6-bit start phase and a fixed length of 43 clocks, which is 3 µs at a 14.318 MHz pixel clock with one clock step of about 70 ns. The second is a supplementary clamp gate. It starts between 80 clocks (5.6 µs) and 95 clocks (6.6 µs) after the edge, set by a 4-bit adjustment, and it lasts 37 clocks (2.6 µs). A select input decides whether the clamp output carries this gate or passes the existing clamp pulse through unchanged.

The horizontal sync comes from one of three lines, chosen by a 2-bit source code. The chosen line passes one register stage, and a second register marks its rising edge. Each gate has its own timer state machine with three states. In `GT_IDLE` the output is low. In `GT_WAIT` the timer counts down the start delay. In `GT_ACTIVE` the gate is high and the timer counts down the length. A sync edge is seen in every state and moves the timer to `GT_WAIT`, or straight to `GT_ACTIVE` when the start value is zero. `GT_WAIT` moves to `GT_ACTIVE` when its count runs out. `GT_ACTIVE` moves to `GT_IDLE` when its count runs out. Each timer loads its start value only at the sync edge. A register change therefore applies from the next edge, and a new edge restarts the timing.

Top module: `hsync_gate_gen`

## Requirements
- R1: While reset is low and after it is released with no sync edge, `burst_gate_o` is low and `clamp_gate_o` follows only `norm_clamp_i` (both low when that input is low).
- R2: If the selected sync is first sampled high at clock edge n, after at least one cycle low, `burst_gate_o` is high from clock edge n+1+P, where P is `bg_phase_i` (0 to 63) as seen at edge n+1.
- R3: `burst_gate_o` stays high for exactly 43 clock cycles when no new sync edge arrives.
- R4: With `clamp_sel_i` high, the supplementary clamp gate on `clamp_gate_o` rises at edge n+1+80+A, where A is `clamp_adj_i` (0 to 15).
- R5: The supplementary clamp gate stays high for exactly 37 clock cycles when no new sync edge arrives.
- R6: `clamp_gate_o` equals the supplementary gate when `clamp_sel_i` is 1 and equals `norm_clamp_i` in the same cycle when `clamp_sel_i` is 0. The mux acts at once and is not held until a sync edge.
- R7: `sync_src_i` picks the sync line: codes 0 and 1 select `hd_i`, code 2 selects `vd_csync_i`, and code 3 selects `sep_sync_i`. Edges on lines that are not selected start no gate.
- R8: A sync edge that arrives while a gate is waiting or active restarts that gate from the new edge. A gate that is high with a nonzero start value goes low on the next cycle.
- R9: `bg_phase_i` and `clamp_adj_i` are sampled only at the sync edge. A change made between edges does not move the gate already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hd_i | input | 1 | Horizontal sync pin, active high |
| vd_csync_i | input | 1 | Vertical or composite sync pin, active high |
| sep_sync_i | input | 1 | Internally separated sync, active high |
| sync_src_i | input | 2 | Sync source code |
| bg_phase_i | input | 6 | Burst gate start delay in clocks |
| clamp_adj_i | input | 4 | Clamp gate start offset above 80 clocks |
| clamp_sel_i | input | 1 | 1: drive supplementary clamp gate, 0: pass normal clamp |
| norm_clamp_i | input | 1 | Normal clamp pulse |
| burst_gate_o | output | 1 | Burst gate |
| clamp_gate_o | output | 1 | Selected clamp gate |

## Verification
The bench drives both ends of each start field (phase 0 and 63, adjustment 0 and 15). With these values a wrong load value or a count off by one moves a gate edge by a cycle. It restarts a gate in the middle of its active window and again while a start is still pending. A timer that ignored edges outside `GT_IDLE` would keep the old window, and one that did not clear the pending start would produce a stray pulse. It changes the start registers while a gate is waiting, to catch a timer that reads the register live instead of latching it at the edge. It toggles the unselected sync lines under each source code, so a swapped mux code shows up as an extra or missing window. It also switches the clamp select to check that the normal clamp pulse passes through in the same cycle.

// File: rtl/hgate_pkg.sv
package hgate_pkg;

    typedef enum logic [1:0] {
        SRC_HD_A = 2'd0,
        SRC_HD_B = 2'd1,
        SRC_VD   = 2'd2,
        SRC_SEP  = 2'd3
    } sync_src_e;

    typedef enum logic [1:0] {
        GT_IDLE   = 2'd0,
        GT_WAIT   = 2'd1,
        GT_ACTIVE = 2'd2
    } gate_state_e;

    function automatic int span_of(input int start_w, input int len);
        int lim;
        lim = 1 << start_w;
        return (lim > len) ? lim : len;
    endfunction

endpackage

// File: rtl/hsync_edge_sel.sv
module hsync_edge_sel
    import hgate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hd_i,
    input  logic       vd_csync_i,
    input  logic       sep_sync_i,
    input  logic [1:0] src_i,
    output logic       edge_o
);

    logic pick;
    logic sync_q;
    logic sync_prev_q;

    // source multiplexer
    always_comb begin
        unique case (sync_src_e'(src_i))
            SRC_HD_A, SRC_HD_B: pick = hd_i;
            SRC_VD:             pick = vd_csync_i;
            SRC_SEP:            pick = sep_sync_i;
            default:            pick = hd_i;
        endcase
    end

    // one sampling stage plus one history stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q      <= 1'b0;
            sync_prev_q <= 1'b0;
        end else begin
            sync_q      <= pick;
            sync_prev_q <= sync_q;
        end
    end

    assign edge_o = sync_q & ~sync_prev_q;

endmodule

// File: rtl/gate_timer.sv
module gate_timer
    import hgate_pkg::*;
#(
    parameter int START_W = 6,
    parameter int LEN     = 43
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_i,
    input  logic [START_W-1:0] start_i,
    output logic               gate_o
);

    localparam int SPAN  = span_of(START_W, LEN);
    localparam int CNT_W = $clog2(SPAN);
    localparam logic [CNT_W-1:0] LEN_M1 = CNT_W'(LEN - 1);

    gate_state_e          st_q, st_d;
    logic [CNT_W-1:0]     cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= GT_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state: an edge wins in every state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (trig_i) begin
            if (start_i == '0) begin
                st_d  = GT_ACTIVE;
                cnt_d = LEN_M1;
            end else begin
                st_d  = GT_WAIT;
                cnt_d = CNT_W'(start_i) - CNT_W'(1);
            end
        end else begin
            unique case (st_q)
                GT_IDLE: begin
                    st_d  = GT_IDLE;
                end
                GT_WAIT: begin
                    if (cnt_q == '0) begin
                        st_d  = GT_ACTIVE;
                        cnt_d = LEN_M1;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                GT_ACTIVE: begin
                    if (cnt_q == '0) begin
                        st_d = GT_IDLE;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                default: begin
                    st_d  = GT_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        gate_o = (st_q == GT_ACTIVE);
    end

endmodule

// File: rtl/hsync_gate_gen.sv
module hsync_gate_gen
    import hgate_pkg::*;
#(
    parameter int PHASE_W        = 6,
    parameter int ADJ_W          = 4,
    parameter int BURST_LEN_CYC  = 43,
    parameter int CLAMP_BASE_CYC = 80,
    parameter int CLAMP_LEN_CYC  = 37
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hd_i,
    input  logic               vd_csync_i,
    input  logic               sep_sync_i,
    input  logic [1:0]         sync_src_i,
    input  logic [PHASE_W-1:0] bg_phase_i,
    input  logic [ADJ_W-1:0]   clamp_adj_i,
    input  logic               clamp_sel_i,
    input  logic               norm_clamp_i,
    output logic               burst_gate_o,
    output logic               clamp_gate_o
);

    localparam int CL_W = $clog2(CLAMP_BASE_CYC + (1 << ADJ_W));

    logic            sync_edge;
    logic            supp_gate;
    logic [CL_W-1:0] clamp_start;

    hsync_edge_sel u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .hd_i       (hd_i),
        .vd_csync_i (vd_csync_i),
        .sep_sync_i (sep_sync_i),
        .src_i      (sync_src_i),
        .edge_o     (sync_edge)
    );

    gate_timer #(
        .START_W (PHASE_W),
        .LEN     (BURST_LEN_CYC)
    ) u_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (sync_edge),
        .start_i (bg_phase_i),
        .gate_o  (burst_gate_o)
    );

    assign clamp_start = CL_W'(CLAMP_BASE_CYC) + CL_W'(clamp_adj_i);

    gate_timer #(
        .START_W (CL_W),
        .LEN     (CLAMP_LEN_CYC)
    ) u_clamp (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (sync_edge),
        .start_i (clamp_start),
        .gate_o  (supp_gate)
    );

    always_comb begin
        clamp_gate_o = clamp_sel_i ? supp_gate : norm_clamp_i;
    end

endmodule

// File: rtl/hsync_gate_chk.sv
module hsync_gate_chk #(
    parameter int PHASE_W        = 6,
    parameter int BURST_LEN_CYC  = 43,
    parameter int CLAMP_BASE_CYC = 80,
    parameter int CLAMP_LEN_CYC  = 37
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sync_edge,
    input logic               burst_gate,
    input logic               supp_gate,
    input logic [PHASE_W-1:0] bg_phase
);

    logic [15:0] burst_run;
    logic [15:0] supp_run;
    logic [15:0] since_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            burst_run  <= '0;
            supp_run   <= '0;
            since_edge <= '0;
        end else begin
            burst_run  <= sync_edge ? '0 : (burst_gate ? burst_run + 16'd1 : '0);
            supp_run   <= sync_edge ? '0 : (supp_gate ? supp_run + 16'd1 : '0);
            if (sync_edge)
                since_edge <= '0;
            else if (since_edge < 16'(CLAMP_BASE_CYC))
                since_edge <= since_edge + 16'd1;
        end
    end

    // R3
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_gate |-> (burst_run < 16'(BURST_LEN_CYC)));

    // R5
    clamp_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        supp_gate |-> (supp_run < 16'(CLAMP_LEN_CYC)));

    // R4
    clamp_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supp_gate) |-> (since_edge >= 16'(CLAMP_BASE_CYC)));

    // R8
    burst_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_edge && burst_gate && (bg_phase != '0)) |=> !burst_gate);

    // R8
    clamp_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_edge |=> !supp_gate);

endmodule

bind hsync_gate_gen hsync_gate_chk #(
    .PHASE_W        (PHASE_W),
    .BURST_LEN_CYC  (BURST_LEN_CYC),
    .CLAMP_BASE_CYC (CLAMP_BASE_CYC),
    .CLAMP_LEN_CYC  (CLAMP_LEN_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_edge  (sync_edge),
    .burst_gate (burst_gate_o),
    .supp_gate  (supp_gate),
    .bg_phase   (bg_phase_i)
);

// File: tb/sim_hsync_gate_gen.sv
module sim_hsync_gate_gen;

    localparam int BLEN  = 43;
    localparam int CBASE = 80;
    localparam int CLEN  = 37;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       hd, vd, sep, csel, nclamp;
    logic [1:0] src;
    logic [5:0] phase;
    logic [3:0] adj;
    logic       burst_o, clamp_o;

    always #4 clk = ~clk;

    hsync_gate_gen u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .hd_i         (hd),
        .vd_csync_i   (vd),
        .sep_sync_i   (sep),
        .sync_src_i   (src),
        .bg_phase_i   (phase),
        .clamp_adj_i  (adj),
        .clamp_sel_i  (csel),
        .norm_clamp_i (nclamp),
        .burst_gate_o (burst_o),
        .clamp_gate_o (clamp_o)
    );

    typedef struct {int rise; int fall;} win_t;
    win_t  qb[$];
    win_t  qc[$];
    win_t  w;
    int    cyc = 0;
    int    nchk = 0, nfail = 0;
    int    rise_b = 0, rise_c = 0, nrise_b = 0, nrise_c = 0;
    logic  pb = 1'b0, pc = 1'b0;
    string tag = "R1";
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: pops an expected window at every observed falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (burst_o && !pb) begin rise_b = cyc; nrise_b++; end
            if (!burst_o && pb) begin
                if (qb.size() == 0) check(1'b0, tag, "unexpected burst window end", cyc, -1);
                else begin
                    w = qb.pop_front();
                    check(rise_b == w.rise, tag, "burst rise cycle", rise_b, w.rise);
                    check(cyc == w.fall, tag, "burst fall cycle", cyc, w.fall);
                end
            end
            pb = burst_o;
            if (csel) begin
                if (clamp_o && !pc) begin rise_c = cyc; nrise_c++; end
                if (!clamp_o && pc) begin
                    if (qc.size() == 0) check(1'b0, tag, "unexpected clamp window end", cyc, -1);
                    else begin
                        w = qc.pop_front();
                        check(rise_c == w.rise, tag, "clamp rise cycle", rise_c, w.rise);
                        check(cyc == w.fall, tag, "clamp fall cycle", cyc, w.fall);
                    end
                end
                pc = clamp_o;
            end else begin
                pc = 1'b0;
            end
        end
    end

    task automatic push_exp(input bit is_clamp, input int t, input int s, input int len);
        win_t q[$];
        q = is_clamp ? qc : qb;
        if (q.size() > 0 && q[q.size()-1].fall > t) begin
            if (q[q.size()-1].rise < t) q[q.size()-1].fall = t;
            else void'(q.pop_back());
        end
        q.push_back('{t + s, t + s + len});
        if (is_clamp) qc = q; else qb = q;
    endtask

    // driver: pin 0 = hd, 1 = vd/csync, 2 = separated sync
    task automatic pulse(input int pin);
        int t;
        bit hit;
        @(posedge clk); #1;
        case (pin)
            0:       hd  = 1'b1;
            1:       vd  = 1'b1;
            default: sep = 1'b1;
        endcase
        t   = cyc + 2;
        hit = (pin == 0 && src < 2) || (pin == 1 && src == 2) || (pin == 2 && src == 3);
        if (hit) begin
            push_exp(1'b0, t, int'(phase), BLEN);
            if (csel) push_exp(1'b1, t, CBASE + int'(adj), CLEN);
        end
        repeat (4) @(posedge clk);
        #1;
        hd = 1'b0; vd = 1'b0; sep = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic drain();
        repeat (170) @(posedge clk);
        @(negedge clk);
        check(qb.size() == 0, tag, "burst windows still pending", qb.size(), 0);
        check(qc.size() == 0, tag, "clamp windows still pending", qc.size(), 0);
    endtask

    task automatic set_regs(input logic [5:0] p, input logic [3:0] a);
        @(posedge clk); #1;
        phase = p; adj = a;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int before_b;
        int highs;
        rst_n = 1'b0; hd = 0; vd = 0; sep = 0; src = 2'd0;
        phase = 6'd14; adj = 4'd0; csel = 1'b1; nclamp = 1'b0;

        // R1: reset state
        tag = "R1";
        repeat (3) @(negedge clk);
        check(burst_o == 1'b0, "R1", "burst gate in reset", burst_o, 0);
        check(clamp_o == 1'b0, "R1", "clamp gate in reset", clamp_o, 0);
        @(posedge clk); #1; rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(burst_o == 1'b0 && clamp_o == 1'b0, "R1", "gates idle after reset",
              int'(burst_o) + int'(clamp_o), 0);

        // R2 R3 R4 R5: nominal phase, clamp at base
        tag = "R2"; pulse(0); drain();
        // R2: phase boundaries 0 and 63
        set_regs(6'd0, 4'd15);  tag = "R2"; pulse(0); drain();
        set_regs(6'd63, 4'd7);  tag = "R3"; pulse(0); drain();
        // R4 R5: clamp adjust top end
        set_regs(6'd20, 4'd15); tag = "R4"; pulse(0); drain();
        tag = "R5"; set_regs(6'd5, 4'd3); pulse(0); drain();

        // R7: source codes and ignored lines
        tag = "R7";
        src = 2'd2; pulse(1); drain();
        before_b = nrise_b;
        pulse(0); pulse(2); drain();
        check(nrise_b == before_b, "R7", "burst rises from unselected lines", nrise_b, before_b);
        src = 2'd3; pulse(2); drain();
        before_b = nrise_b;
        pulse(0); pulse(1); drain();
        check(nrise_b == before_b, "R7", "rises with sep source from other pins", nrise_b, before_b);
        src = 2'd1; pulse(0); drain();
        src = 2'd0;

        // R8: restart while active, and while waiting
        tag = "R8";
        set_regs(6'd10, 4'd2);
        pulse(0);
        repeat (12) @(posedge clk);
        pulse(0); drain();
        set_regs(6'd50, 4'd9);
        pulse(0);
        pulse(0); drain();

        // R9: register change mid-wait has no effect until next edge
        tag = "R9";
        set_regs(6'd40, 4'd12);
        pulse(0);
        set_regs(6'd3, 4'd1);
        drain();
        pulse(0); drain();

        // R6: clamp mux passes normal clamp in the same cycle
        tag = "R6";
        csel = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1; nclamp = i[0];
            @(negedge clk);
            check(clamp_o == nclamp, "R6", "clamp passes normal pulse", clamp_o, nclamp);
        end
        nclamp = 1'b0;
        pulse(0);
        highs = 0;
        for (int i = 0; i < 160; i++) begin
            @(negedge clk);
            if (clamp_o) highs++;
        end
        check(highs == 0, "R6", "supplementary gate hidden when deselected", highs, 0);
        check(qb.size() == 0, "R6", "burst window still pending", qb.size(), 0);
        csel = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

endmodule